// File: doc/BRIEF.md
# Multi-Mode Nibble I/O Port Group

This block holds three 4-bit general-purpose I/O ports that a small processor core reaches through an accumulator-style access path. In one clock cycle an access either copies the accumulator nibble into the output latch of the selected port, or captures that port's current state into the accumulator. The block exposes each port's pad as three vectors: the value to drive, the drive enable, and the level seen on the pin. The surrounding pad cells combine these into the real wire.

Port A and port B are open-drain ports. A latch bit of 0 pulls the pin low. A latch bit of 1 releases the pin, so the pin can then serve as an input. Port A can be built at full width or as a reduced 2-bit port. Port B shares its four pins with four converter inputs. An analog-control vector takes a pin away from the port one bit at a time. Port P is a push-pull port with a per-bit direction register. The direction register is written and read through a fourth select code.

Top module: `nibble_io_group`

## Requirements
- R1: Synchronous reset (active-high `rst`) has the following effects: every open-drain latch bit becomes 1, so `a_pad_oe` and `b_pad_oe` are all 0; every direction bit becomes 0, so `p_pad_oe` is all 0; the push-pull latch becomes 0; `acc_out` becomes 0.
- R2: With `sel`=0 (port A) or `sel`=1 (port B), `wr` copies `acc_in` (its low `A_BITS` bits for port A) into that port's latch. From the next cycle on, pad bit i has its enable equal to the inverse of latch bit i, and its drive value is always 0.
- R3: With `rd` and `sel`=0, bit i of `acc_out` becomes (latch bit i AND pin bit i) on the next cycle. A latch bit of 0 therefore reads as 0 whatever the external level is.
- R4: When `A_BITS`=2, a read of port A returns 0 in `acc_out[3:2]`.
- R5: While `ana_ctl[i]` is 1, port B pin i is disabled: `b_pad_oe[i]` is 0 and a read with `sel`=1 returns 0 in bit i. A write with `sel`=1 still updates latch bit i, and the latch value takes effect once `ana_ctl[i]` returns to 0.
- R6: With `sel`=3, `wr` loads `acc_in` into the direction register and `rd` returns the direction register. A direction bit of 0 turns off the port P driver for that bit.
- R7: With `sel`=2, `wr` loads the push-pull latch. `p_pad_oe` equals the direction register and `p_pad_out` equals the latch, so the pin drives both levels when it is enabled.
- R8: With `rd` and `sel`=2, bit i of `acc_out` is the latch bit when direction bit i is 1, and the pin level when direction bit i is 0.
- R9: A read result appears on `acc_out` exactly one cycle after the `rd` cycle and holds while `rd` is low. When `rd` and `wr` occur in the same cycle, the read captures the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Target: 0 port A, 1 port B, 2 port P, 3 direction register |
| wr | input | 1 | Output-operation strobe |
| rd | input | 1 | Input-operation strobe |
| acc_in | input | NIB | Accumulator nibble to write |
| acc_out | output | NIB | Registered captured nibble |
| ana_ctl | input | NIB | Per-pin analog claim for port B |
| a_pin_in | input | A_BITS | Port A pin levels |
| a_pad_out | output | A_BITS | Port A drive value |
| a_pad_oe | output | A_BITS | Port A drive enable |
| b_pin_in | input | NIB | Port B pin levels |
| b_pad_out | output | NIB | Port B drive value |
| b_pad_oe | output | NIB | Port B drive enable |
| p_pin_in | input | NIB | Port P pin levels |
| p_pad_out | output | NIB | Port P drive value |
| p_pad_oe | output | NIB | Port P drive enable |

## Verification
Several properties are checked by assertions on every cycle. They cover the reset pad state, the enable pattern after an open-drain write or a direction write, the rule that an analog-claimed pin never drives, and readback of an output-direction port P. They also check that `acc_out` holds between reads. Other behaviours are shown only by the bench scenarios, which compare against a reference model. These include the AND of latch and pin level on open-drain reads, a latch write hidden behind the analog claim that appears after release, the mixed-direction read of port P, read-before-write ordering within a cycle, and the zeroed upper bits of the reduced port.

// File: rtl/nibble_io_pkg.sv
package nibble_io_pkg;
  typedef enum logic [1:0] {
    SEL_OD  = 2'd0,
    SEL_ANA = 2'd1,
    SEL_PP  = 2'd2,
    SEL_DIR = 2'd3
  } port_sel_e;
endpackage

// File: rtl/nio_od_port.sv
module nio_od_port #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] usable,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst)        latch_q <= '1;
    else if (wr_en) latch_q <= wdata;
  end

  // open drain: only ever pulls low
  assign pad_out = '0;
  assign pad_oe  = ~latch_q & usable;
  assign rd_val  = latch_q & pin_in & usable;
endmodule

// File: rtl/nio_pp_port.sv
module nio_pp_port #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         dir_wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] dir,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_en)     latch_q <= wdata;
      if (dir_wr_en) dir_q   <= wdata;
    end
  end

  assign dir     = dir_q;
  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
  assign rd_val  = (dir_q & latch_q) | (~dir_q & pin_in);
endmodule

// File: rtl/nibble_io_group.sv
module nibble_io_group
  import nibble_io_pkg::*;
#(
  parameter int NIB    = 4,
  parameter int A_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [NIB-1:0]    acc_in,
  output logic [NIB-1:0]    acc_out,
  input  logic [NIB-1:0]    ana_ctl,
  input  logic [A_BITS-1:0] a_pin_in,
  output logic [A_BITS-1:0] a_pad_out,
  output logic [A_BITS-1:0] a_pad_oe,
  input  logic [NIB-1:0]    b_pin_in,
  output logic [NIB-1:0]    b_pad_out,
  output logic [NIB-1:0]    b_pad_oe,
  input  logic [NIB-1:0]    p_pin_in,
  output logic [NIB-1:0]    p_pad_out,
  output logic [NIB-1:0]    p_pad_oe
);
  localparam int A_PAD = NIB - A_BITS;

  port_sel_e         sel_e;
  logic [A_BITS-1:0] a_rd;
  logic [NIB-1:0]    a_ext, b_rd, p_rd, p_dir, rd_mux;

  assign sel_e = port_sel_e'(sel);

  nio_od_port #(.W(A_BITS)) u_port_a (
    .clk(clk), .rst(rst),
    .wr_en(wr && sel_e == SEL_OD),
    .wdata(acc_in[A_BITS-1:0]),
    .usable({A_BITS{1'b1}}),
    .pin_in(a_pin_in),
    .pad_out(a_pad_out), .pad_oe(a_pad_oe), .rd_val(a_rd)
  );

  nio_od_port #(.W(NIB)) u_port_b (
    .clk(clk), .rst(rst),
    .wr_en(wr && sel_e == SEL_ANA),
    .wdata(acc_in),
    .usable(~ana_ctl),
    .pin_in(b_pin_in),
    .pad_out(b_pad_out), .pad_oe(b_pad_oe), .rd_val(b_rd)
  );

  nio_pp_port #(.W(NIB)) u_port_p (
    .clk(clk), .rst(rst),
    .wr_en(wr && sel_e == SEL_PP),
    .dir_wr_en(wr && sel_e == SEL_DIR),
    .wdata(acc_in),
    .pin_in(p_pin_in),
    .dir(p_dir),
    .pad_out(p_pad_out), .pad_oe(p_pad_oe), .rd_val(p_rd)
  );

  generate
    if (A_PAD > 0) begin : g_narrow
      assign a_ext = {{A_PAD{1'b0}}, a_rd};
    end else begin : g_full
      assign a_ext = a_rd;
    end
  endgenerate

  always_comb begin
    unique case (sel_e)
      SEL_OD:  rd_mux = a_ext;
      SEL_ANA: rd_mux = b_rd;
      SEL_PP:  rd_mux = p_rd;
      default: rd_mux = p_dir;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_out <= '0;
    else if (rd) acc_out <= rd_mux;
  end
endmodule

// File: rtl/nibble_io_group_chk.sv
module nibble_io_group_chk #(
  parameter int NIB    = 4,
  parameter int A_BITS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        sel,
  input logic              wr,
  input logic              rd,
  input logic [NIB-1:0]    acc_in,
  input logic [NIB-1:0]    acc_out,
  input logic [NIB-1:0]    ana_ctl,
  input logic [A_BITS-1:0] a_pad_oe,
  input logic [NIB-1:0]    b_pad_oe,
  input logic [NIB-1:0]    p_pad_out,
  input logic [NIB-1:0]    p_pad_oe
);
  a_r1_reset_pads: assert property (@(posedge clk)
    rst |=> (a_pad_oe == '0 && b_pad_oe == '0 && p_pad_oe == '0 && acc_out == '0));

  a_r2_od_write: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == 2'd0) |=> (a_pad_oe == ~$past(acc_in[A_BITS-1:0])));

  a_r5_ana_quiet: assert property (@(posedge clk) disable iff (rst)
    (ana_ctl & b_pad_oe) == '0);

  a_r6_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == 2'd3) |=> (p_pad_oe == $past(acc_in)));

  a_r8_pp_readback: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == 2'd2 && p_pad_oe == '1) |=> (acc_out == $past(p_pad_out)));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(acc_out));
endmodule

bind nibble_io_group nibble_io_group_chk #(.NIB(NIB), .A_BITS(A_BITS)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd(rd), .acc_in(acc_in),
  .acc_out(acc_out), .ana_ctl(ana_ctl), .a_pad_oe(a_pad_oe),
  .b_pad_oe(b_pad_oe), .p_pad_out(p_pad_out), .p_pad_oe(p_pad_oe)
);

// File: tb/nibble_io_group_tb.sv
module nibble_io_group_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [3:0] acc_in = '0, ana_ctl = '0;
  logic [3:0] a_pin = '0, b_pin = '0, p_pin = '0;
  logic [3:0] acc_out, a_out, a_oe, b_out, b_oe, p_out, p_oe;
  logic [3:0] r_acc;
  logic [1:0] r_aout, r_aoe;
  logic [3:0] r_bout, r_boe, r_pout, r_poe;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  // reference model state
  logic [3:0] m_la, m_lb, m_lp, m_dir, m_acc, m_rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_io_group #(.NIB(4), .A_BITS(4)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd(rd), .acc_in(acc_in),
    .acc_out(acc_out), .ana_ctl(ana_ctl),
    .a_pin_in(a_pin), .a_pad_out(a_out), .a_pad_oe(a_oe),
    .b_pin_in(b_pin), .b_pad_out(b_out), .b_pad_oe(b_oe),
    .p_pin_in(p_pin), .p_pad_out(p_out), .p_pad_oe(p_oe)
  );

  nibble_io_group #(.NIB(4), .A_BITS(2)) u_red (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd(rd), .acc_in(acc_in),
    .acc_out(r_acc), .ana_ctl(ana_ctl),
    .a_pin_in(a_pin[1:0]), .a_pad_out(r_aout), .a_pad_oe(r_aoe),
    .b_pin_in(b_pin), .b_pad_out(r_bout), .b_pad_oe(r_boe),
    .p_pin_in(p_pin), .p_pad_out(r_pout), .p_pad_oe(r_poe)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_la = 4'hF; m_lb = 4'hF; m_lp = 4'h0; m_dir = 4'h0; m_acc = 4'h0;
    end else begin
      if (rd) begin
        case (sel)
          2'd0: m_rv = m_la & a_pin;
          2'd1: m_rv = m_lb & b_pin & ~ana_ctl;
          2'd2: m_rv = (m_dir & m_lp) | (~m_dir & p_pin);
          default: m_rv = m_dir;
        endcase
        m_acc = m_rv;
      end
      if (wr) begin
        case (sel)
          2'd0: m_la = acc_in;
          2'd1: m_lb = acc_in;
          2'd2: m_lp = acc_in;
          default: m_dir = acc_in;
        endcase
      end
    end
  end

  task automatic chk(string what, logic [3:0] act, logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("acc_out", acc_out, m_acc);
    chk("a_pad_oe", a_oe, ~m_la);
    chk("a_pad_out", a_out, 4'h0);
    chk("b_pad_oe", b_oe, ~m_lb & ~ana_ctl);
    chk("b_pad_out", b_out, 4'h0);
    chk("p_pad_oe", p_oe, m_dir);
    chk("p_pad_out", p_out, m_lp);
  endtask

  task automatic cyc(logic [1:0] s, logic w, logic r, logic [3:0] d);
    sel = s; wr = w; rd = r; acc_in = d;
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    cur_req = "R1"; compare_all();
    rst = 1'b0;
    cyc(2'd0, 0, 0, 4'h0);
    cur_req = "R1"; chk("r1_red_oe", {2'b00, r_aoe}, 4'h0);

    cur_req = "R2";
    cyc(2'd0, 1, 0, 4'h5);
    cyc(2'd1, 1, 0, 4'h3);
    chk("r2_a_oe", a_oe, 4'hA);

    cur_req = "R3";
    a_pin = 4'hF; cyc(2'd0, 0, 1, 4'h0);
    chk("r3_read_and", acc_out, 4'h5);
    a_pin = 4'h0; cyc(2'd0, 0, 1, 4'h0);
    a_pin = 4'hC; cyc(2'd0, 0, 1, 4'h0);
    chk("r3_pattern", acc_out, 4'h4);

    cur_req = "R4";
    a_pin = 4'hF; cyc(2'd0, 1, 0, 4'hF);
    cyc(2'd0, 0, 1, 4'h0);
    chk("r4_upper_zero", r_acc, 4'h3);

    cur_req = "R5";
    ana_ctl = 4'h3; b_pin = 4'hF;
    cyc(2'd1, 1, 0, 4'h0);
    chk("r5_oe_masked", b_oe, 4'hC);
    cyc(2'd1, 1, 0, 4'hF);
    cyc(2'd1, 0, 1, 4'h0);
    chk("r5_read_zero", acc_out, 4'hC);
    cyc(2'd1, 1, 0, 4'hC);
    ana_ctl = 4'h0; cyc(2'd2, 0, 0, 4'h0);
    chk("r5_latch_kept", b_oe, 4'h3);

    cur_req = "R6";
    cyc(2'd3, 1, 0, 4'hC);
    cyc(2'd3, 0, 1, 4'h0);
    chk("r6_dir_read", acc_out, 4'hC);

    cur_req = "R7";
    cyc(2'd2, 1, 0, 4'hA);
    chk("r7_pp_drive", p_out & p_oe, 4'h8);

    cur_req = "R8";
    p_pin = 4'h5; cyc(2'd2, 0, 1, 4'h0);
    chk("r8_mixed", acc_out, 4'h9);
    cyc(2'd3, 1, 0, 4'hF);
    p_pin = 4'h0; cyc(2'd2, 0, 1, 4'h0);
    chk("r8_all_out", acc_out, 4'hA);

    cur_req = "R9";
    cyc(2'd2, 1, 1, 4'h6);
    chk("r9_read_before_write", acc_out, 4'hA);
    p_pin = 4'hF;
    cyc(2'd2, 0, 0, 4'h0);
    cyc(2'd0, 0, 0, 4'h0);
    chk("r9_hold", acc_out, 4'hA);
    cyc(2'd2, 0, 1, 4'h0);
    chk("r9_new_read", acc_out, 4'h6);

    cur_req = "R1";
    rst = 1'b1; cyc(2'd0, 0, 0, 4'h0);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule